// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Per-Character Error Flags

This block turns an idle-high asynchronous serial line back into characters. An external baud enable supplies a sampling tick at 16 times the bit rate. The block finds the start of a frame and checks that it is real. It then samples each data bit, the optional parity bit and the first stop bit at the middle of the bit, and builds the character in a shift buffer. When the first stop bit has been sampled, the finished character moves into a one-entry holding register together with its framing, parity and overrun flags. The host reads it from there while the next frame is already coming in.

The frame format is set by static inputs: 5 to 9 data bits sent least significant bit first, no parity or even or odd parity, and one or two stop bits. The receiver checks only the first stop bit. It can start on the next frame right after that bit, so it does not need to know the stop-bit count. A read strobe tells the block that the host has taken the character.

Top module: `async_rx`

## Requirements
- R1: The line input passes through a two-flop synchroniser. A frame can begin only on a sampling tick where the synchronised line is low and was high at the previous tick seen while idle. The start is accepted only if the line is still low 8 ticks later. Otherwise it is treated as a glitch and no character is produced.
- R2: Data bits are received least significant bit first, with the count given by `dataBits` (values 5 to 9). Bit positions at or above that count read as 0.
- R3: Data bits 0 to 7 appear on `rxData`, and data bit 8 (the ninth bit) appears on `rxBit8`.
- R4: With `parityOn`=1 a parity bit follows the data. The expected value is the XOR of the data bits when `parityOdd`=0 (even), and its inverse when `parityOdd`=1 (odd). A mismatch sets `parityErr`. With `parityOn`=0 no parity bit is taken and `parityErr` is 0.
- R5: `frameErr` is 1 for a character whose first stop bit was sampled as 0.
- R6: Only the first stop bit is sampled. A new start bit may follow the first stop bit at once and is received correctly.
- R7: When the first stop bit is sampled, the character and all three flags load together, and `rxValid` rises. A one-cycle `rxRead` pulse clears `rxValid`. The data and flags stay unchanged until the next character loads.
- R8: `overrunErr` is 1 for a character that loaded while `rxValid` was still 1 and no read happened in that cycle. In that case the new character replaces the old one.
- R9: After reset, `rxValid`, `rxData`, `rxBit8` and all flags are 0.
- R10: After a frame whose stop bit was 0, the line held low does not start a new frame. The line must return high first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sampleTick | input | 1 | Oversampling enable, 16 per bit |
| rxLine | input | 1 | Serial line, idle high |
| dataBits | input | 4 | Data bits per character, 5 to 9 |
| parityOn | input | 1 | Parity bit present |
| parityOdd | input | 1 | 1 = odd parity, 0 = even parity |
| rxRead | input | 1 | Host read strobe, one cycle |
| rxData | output | 8 | Received data bits 0 to 7 |
| rxBit8 | output | 1 | Received ninth data bit |
| rxValid | output | 1 | Unread character present |
| frameErr | output | 1 | First stop bit was 0 |
| parityErr | output | 1 | Parity mismatch |
| overrunErr | output | 1 | Previous character was overwritten unread |

## Verification
The main receive path is driven with a table of frames that covers several data widths (5, 6, 7, 8 and 9 bits), each parity mode, and one or two stop bits. The table also has frames with a corrupted parity bit or a zero stop bit. These frames separate correct bit ordering and width masking from errors in the parity polarity and the stop-bit check.

Directed cases cover the remaining behaviour:
- A short low pulse, which must be rejected as a glitch.
- Two frames sent back to back with no idle gap, which shows that the second stop bit is never needed.
- Two unread characters in a row, which must give an overrun.
- A line held low after a framing error, which must not start a new frame.

// File: rtl/async_rx_pkg.sv
package async_rx_pkg;
  typedef struct packed {
    logic clearBuf;
    logic takeData;
    logic takeParity;
    logic commit;
  } rxStrobe_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PARITY,
    ST_STOP
  } rxState_t;
endpackage

// File: rtl/async_rx_ctrl.sv
module async_rx_ctrl
  import async_rx_pkg::*;
#(
  parameter int OVERSAMPLE = 16,
  parameter int MAX_BITS   = 9
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         sampleTick,
  input  logic                         lineS,
  input  logic [3:0]                   dataBits,
  input  logic                         parityOn,
  output rxStrobe_t                    strobe,
  output logic [$clog2(MAX_BITS)-1:0]  bitIdx
);
  localparam int CNTW = $clog2(OVERSAMPLE);
  localparam int HALF = OVERSAMPLE / 2;
  localparam int IDXW = $clog2(MAX_BITS);

  rxState_t        state;
  logic [CNTW-1:0] tickCnt;
  logic            lastHigh;
  logic            atHalf;
  logic            atFull;
  logic            lastBit;

  assign atHalf  = sampleTick && (tickCnt == CNTW'(HALF - 1));
  assign atFull  = sampleTick && (tickCnt == CNTW'(OVERSAMPLE - 1));
  assign lastBit = (bitIdx == IDXW'(dataBits - 4'd1));

  always_comb begin
    strobe            = '0;
    strobe.clearBuf   = (state == ST_START) && atHalf && !lineS;
    strobe.takeData   = (state == ST_DATA) && atFull;
    strobe.takeParity = (state == ST_PARITY) && atFull;
    strobe.commit     = (state == ST_STOP) && atFull;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      tickCnt  <= '0;
      bitIdx   <= '0;
      lastHigh <= 1'b0;
    end else if (sampleTick) begin
      case (state)
        ST_IDLE: begin
          lastHigh <= lineS;
          tickCnt  <= '0;
          if (!lineS && lastHigh) state <= ST_START;
        end
        ST_START: begin
          if (atHalf) begin
            tickCnt <= '0;
            bitIdx  <= '0;
            if (!lineS) begin
              state <= ST_DATA;
            end else begin
              state    <= ST_IDLE;
              lastHigh <= 1'b1;
            end
          end else begin
            tickCnt <= tickCnt + 1'b1;
          end
        end
        ST_DATA: begin
          tickCnt <= tickCnt + 1'b1;
          if (atFull) begin
            if (lastBit) state <= parityOn ? ST_PARITY : ST_STOP;
            else         bitIdx <= bitIdx + 1'b1;
          end
        end
        ST_PARITY: begin
          tickCnt <= tickCnt + 1'b1;
          if (atFull) state <= ST_STOP;
        end
        ST_STOP: begin
          tickCnt <= tickCnt + 1'b1;
          if (atFull) begin
            state    <= ST_IDLE;
            lastHigh <= lineS;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobe));

  // R2
  bit_idx_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DATA) |-> (bitIdx < IDXW'(MAX_BITS)));

  // R1
  glitch_reject_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_START && atHalf && lineS) |=> (state == ST_IDLE));

  // R10
  no_start_while_unarmed_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && !lastHigh) |=> (state == ST_IDLE));
endmodule

// File: rtl/async_rx_dpath.sv
module async_rx_dpath
  import async_rx_pkg::*;
#(
  parameter int MAX_BITS    = 9,
  parameter int SYNC_STAGES = 2
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         rxLine,
  input  rxStrobe_t                    strobe,
  input  logic [$clog2(MAX_BITS)-1:0]  bitIdx,
  input  logic                         parityOn,
  input  logic                         parityOdd,
  input  logic                         rxRead,
  output logic                         lineS,
  output logic [MAX_BITS-1:0]          rxWord,
  output logic                         rxValid,
  output logic                         frameErr,
  output logic                         parityErr,
  output logic                         overrunErr
);
  logic [SYNC_STAGES-1:0] syncReg;
  logic [MAX_BITS-1:0]    shiftBuf;
  logic                   parAcc;
  logic                   parBad;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncReg <= '1;
    else       syncReg <= {syncReg[SYNC_STAGES-2:0], rxLine};
  end
  assign lineS = syncReg[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftBuf <= '0;
      parAcc   <= 1'b0;
      parBad   <= 1'b0;
    end else if (strobe.clearBuf) begin
      shiftBuf <= '0;
      parAcc   <= 1'b0;
      parBad   <= 1'b0;
    end else if (strobe.takeData) begin
      shiftBuf[bitIdx] <= lineS;
      parAcc           <= parAcc ^ lineS;
    end else if (strobe.takeParity) begin
      parBad <= ((parAcc ^ parityOdd) != lineS);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxWord     <= '0;
      rxValid    <= 1'b0;
      frameErr   <= 1'b0;
      parityErr  <= 1'b0;
      overrunErr <= 1'b0;
    end else if (strobe.commit) begin
      rxWord     <= shiftBuf;
      rxValid    <= 1'b1;
      frameErr   <= !lineS;
      parityErr  <= parityOn && parBad;
      overrunErr <= rxValid && !rxRead;
    end else if (rxRead) begin
      rxValid <= 1'b0;
    end
  end

  // R7
  commit_sets_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.commit |=> rxValid);

  // R7
  read_clears_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rxRead && !strobe.commit) |=> !rxValid);

  // R7
  word_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.commit |=> ($stable(rxWord) && $stable(frameErr)
                        && $stable(parityErr) && $stable(overrunErr)));

  // R8
  overrun_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.commit && rxValid && !rxRead) |=> overrunErr);

  // R4
  no_parity_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.commit && !parityOn) |=> !parityErr);
endmodule

// File: rtl/async_rx.sv
module async_rx
  import async_rx_pkg::*;
#(
  parameter int OVERSAMPLE  = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sampleTick,
  input  logic       rxLine,
  input  logic [3:0] dataBits,
  input  logic       parityOn,
  input  logic       parityOdd,
  input  logic       rxRead,
  output logic [7:0] rxData,
  output logic       rxBit8,
  output logic       rxValid,
  output logic       frameErr,
  output logic       parityErr,
  output logic       overrunErr
);
  localparam int MAX_BITS = 9;
  localparam int IDXW     = $clog2(MAX_BITS);

  rxStrobe_t           strobe;
  logic [IDXW-1:0]     bitIdx;
  logic                lineS;
  logic [MAX_BITS-1:0] rxWord;

  async_rx_ctrl #(.OVERSAMPLE(OVERSAMPLE), .MAX_BITS(MAX_BITS)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .sampleTick (sampleTick),
    .lineS      (lineS),
    .dataBits   (dataBits),
    .parityOn   (parityOn),
    .strobe     (strobe),
    .bitIdx     (bitIdx)
  );

  async_rx_dpath #(.MAX_BITS(MAX_BITS), .SYNC_STAGES(SYNC_STAGES)) u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .rxLine     (rxLine),
    .strobe     (strobe),
    .bitIdx     (bitIdx),
    .parityOn   (parityOn),
    .parityOdd  (parityOdd),
    .rxRead     (rxRead),
    .lineS      (lineS),
    .rxWord     (rxWord),
    .rxValid    (rxValid),
    .frameErr   (frameErr),
    .parityErr  (parityErr),
    .overrunErr (overrunErr)
  );

  assign rxData = rxWord[7:0];
  assign rxBit8 = rxWord[8];
endmodule

// File: tb/async_rx_tb.sv
module async_rx_tb;
  localparam int BIT_CLKS = 32;
  localparam int NV = 8;
  // [17:14] data bits, [13] parity on, [12] odd, [11] flip parity,
  // [10] stop value, [9] two stops, [8:0] data
  localparam logic [17:0] VEC [NV] = '{
    {4'd8, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 9'h0A5},
    {4'd8, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 9'h03C},
    {4'd7, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 9'h05A},
    {4'd5, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 9'h015},
    {4'd9, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 9'h1C3},
    {4'd8, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 9'h081},
    {4'd6, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 9'h02D},
    {4'd8, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 9'h0FF}
  };

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       sampleTick = 1'b0;
  logic       rxLine = 1'b1;
  logic [3:0] dataBits = 4'd8;
  logic       parityOn = 1'b0;
  logic       parityOdd = 1'b0;
  logic       rxRead = 1'b0;
  logic [7:0] rxData;
  logic       rxBit8, rxValid, frameErr, parityErr, overrunErr;

  int checks = 0;
  int errors = 0;

  async_rx u_dut (
    .clk(clk), .rstN(rstN), .sampleTick(sampleTick), .rxLine(rxLine),
    .dataBits(dataBits), .parityOn(parityOn), .parityOdd(parityOdd),
    .rxRead(rxRead), .rxData(rxData), .rxBit8(rxBit8), .rxValid(rxValid),
    .frameErr(frameErr), .parityErr(parityErr), .overrunErr(overrunErr)
  );

  always #10 clk = ~clk;

  initial forever begin
    @(negedge clk);
    sampleTick = ~sampleTick;
  end

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic sendBit(input logic v);
    rxLine = v;
    repeat (BIT_CLKS) @(negedge clk);
  endtask

  task automatic sendFrame(input int n, input logic pOn, input logic pOdd,
                           input logic [8:0] d, input logic flip,
                           input logic stopV, input logic twoStop);
    logic p;
    p = pOdd ^ flip;
    sendBit(1'b0);
    for (int i = 0; i < n; i++) begin
      sendBit(d[i]);
      p = p ^ d[i];
    end
    if (pOn) sendBit(p);
    sendBit(stopV);
    if (twoStop) sendBit(1'b1);
    rxLine = 1'b1;
  endtask

  task automatic doRead();
    @(negedge clk);
    rxRead = 1'b1;
    @(negedge clk);
    rxRead = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [8:0] expD;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    // R9 reset state
    check("R9 valid", 16'(rxValid), 16'h0);
    check("R9 data", {7'h0, rxBit8, rxData}, 16'h0);
    check("R9 flags", {13'h0, frameErr, parityErr, overrunErr}, 16'h0);
    repeat (BIT_CLKS) @(negedge clk);

    // Table-driven frames: R2 R3 R4 R5 R7
    for (int v = 0; v < NV; v++) begin
      dataBits  = VEC[v][17:14];
      parityOn  = VEC[v][13];
      parityOdd = VEC[v][12];
      repeat (BIT_CLKS) @(negedge clk);
      sendFrame(int'(VEC[v][17:14]), VEC[v][13], VEC[v][12], VEC[v][8:0],
                VEC[v][11], VEC[v][10], VEC[v][9]);
      @(negedge clk);
      expD = VEC[v][8:0] & 9'((1 << VEC[v][17:14]) - 1);
      check("R7 valid after frame", 16'(rxValid), 16'h1);
      check("R2 data", 16'(rxData), 16'(expD[7:0]));
      check("R3 ninth bit", 16'(rxBit8), 16'(expD[8]));
      check("R4 parity flag", 16'(parityErr), 16'(VEC[v][13] & VEC[v][11]));
      check("R5 frame flag", 16'(frameErr), 16'(!VEC[v][10]));
      check("R8 no overrun", 16'(overrunErr), 16'h0);
      doRead();
      check("R7 read clears valid", 16'(rxValid), 16'h0);
      check("R7 flags held", {14'h0, frameErr, parityErr},
            {14'h0, !VEC[v][10], VEC[v][13] & VEC[v][11]});
      check("R7 data held", 16'(rxData), 16'(expD[7:0]));
    end

    dataBits = 4'd8; parityOn = 1'b0; parityOdd = 1'b0;
    repeat (BIT_CLKS) @(negedge clk);

    // R1 glitch shorter than half a bit
    rxLine = 1'b0;
    repeat (8) @(negedge clk);
    rxLine = 1'b1;
    repeat (12 * BIT_CLKS) @(negedge clk);
    check("R1 glitch ignored", 16'(rxValid), 16'h0);

    // R8 overrun: two unread characters
    sendFrame(8, 1'b0, 1'b0, 9'h011, 1'b0, 1'b1, 1'b0);
    repeat (BIT_CLKS) @(negedge clk);
    sendFrame(8, 1'b0, 1'b0, 9'h022, 1'b0, 1'b1, 1'b0);
    @(negedge clk);
    check("R8 overrun set", 16'(overrunErr), 16'h1);
    check("R8 newer data kept", 16'(rxData), 16'h22);
    doRead();
    sendFrame(8, 1'b0, 1'b0, 9'h033, 1'b0, 1'b1, 1'b0);
    @(negedge clk);
    check("R8 overrun cleared by next char", 16'(overrunErr), 16'h0);
    doRead();
    repeat (BIT_CLKS) @(negedge clk);

    // R6 back-to-back frames, one stop bit, no idle gap
    sendFrame(8, 1'b0, 1'b0, 9'h0C6, 1'b0, 1'b1, 1'b0);
    sendFrame(8, 1'b0, 1'b0, 9'h05D, 1'b0, 1'b1, 1'b0);
    @(negedge clk);
    check("R6 second frame data", 16'(rxData), 16'h5D);
    check("R6 second frame no frame error", 16'(frameErr), 16'h0);
    doRead();
    repeat (BIT_CLKS) @(negedge clk);

    // R10 line stuck low after a framing error
    rxLine = 1'b0;
    repeat (BIT_CLKS) @(negedge clk);
    for (int i = 0; i < 8; i++) sendBit(1'b0);
    rxLine = 1'b0;
    repeat (BIT_CLKS) @(negedge clk);
    check("R10 bad stop recorded", 16'(frameErr), 16'h1);
    doRead();
    repeat (14 * BIT_CLKS) @(negedge clk);
    check("R10 no frame while line low", 16'(rxValid), 16'h0);
    rxLine = 1'b1;
    repeat (2 * BIT_CLKS) @(negedge clk);
    sendFrame(8, 1'b0, 1'b0, 9'h0E7, 1'b0, 1'b1, 1'b0);
    @(negedge clk);
    check("R10 recovers after high", 16'(rxData), 16'hE7);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule